// File: doc/BRIEF.md
# Pipelined Burst Response Tracker

This block watches a request/response link in which every fill request from the master must be answered by a fixed number of transfer beats from the slave (four by default). The master may send another fill before the beats of earlier fills have all arrived. Instead of pairing each request with a particular group of beats, the tracker keeps one running total of beats still owed. Each accepted fill adds a full burst to the total, and each accepted beat takes one away.

The tracker is a passive monitor. It drives the owed-beat total, a busy flag, a one-cycle pulse when a burst finishes, and a one-cycle error pulse when the traffic breaks the rules. A beat that arrives when no beat is owed is an error. A fill that would push the total past the width of the counter is also an error. The slave may leave idle cycles between beats. Bursts always drain in the order their fills were issued.

Top module: `burst_beat_tracker`

## Requirements
- R1: A fill request with no beat in the same cycle adds BEATS (4) to `pend_beats`, provided the new total fits in CNT_W bits.
- R2: A beat with no fill in the same cycle, while `pend_beats` is nonzero, lowers `pend_beats` by one.
- R3: A fill and a beat in the same cycle change `pend_beats` by BEATS minus one (plus three). This holds when the total is zero, because the beat then belongs to the new fill.
- R4: A cycle with neither a fill nor a beat leaves `pend_beats` unchanged.
- R5: A fill is accepted while beats of earlier fills are still owed, and its beats add to the ones already owed.
- R6: `burst_done` is high for exactly one cycle, in the cycle after the clock edge that samples a beat consuming the last beat of a burst. That is a beat taken against earlier fills while `pend_beats` modulo BEATS equals one (for BEATS = 4, a value of 1, 5, 9 and so on).
- R7: `busy` is high exactly when `pend_beats` is nonzero.
- R8: A beat with no fill in the same cycle, while `pend_beats` is zero, raises `proto_err` for one cycle and leaves `pend_beats` at zero.
- R9: A fill is rejected when `pend_beats` plus BEATS, less one for a beat taken against earlier fills in the same cycle, exceeds 2^CNT_W - 1. A rejected fill raises `proto_err` for one cycle and adds nothing. Any beat in that cycle is still applied as in R2 or R8.
- R10: While `rst_n` is low, `pend_beats`, `burst_done` and `proto_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_req | input | 1 | Fill request strobe from the master |
| beat_vld | input | 1 | Transfer beat strobe from the slave |
| pend_beats | output | CNT_W | Number of beats still owed |
| busy | output | 1 | High while any beat is owed |
| burst_done | output | 1 | One-cycle pulse when a burst's last beat is consumed |
| proto_err | output | 1 | One-cycle pulse on a stray beat or a rejected fill |

## Verification
All results come from registers. A fill or beat sampled at one rising edge is reflected in `pend_beats`, `busy`, `burst_done` and `proto_err` right after that same edge, and each pulse clears at the next edge. The bench drives its inputs on the falling edge and advances its reference model at that moment. It then waits one rising edge and compares all four outputs on the following falling edge, before it drives anything new. As a result, every compare lands exactly one sampling edge after the stimulus it judges.

// File: rtl/burst_trk_pkg.sv
package burst_trk_pkg;

  // Per-cycle decisions of the tracker, shared by the datapath and the checker
  typedef struct packed {
    logic fill_ok;     // fill accepted into the owed total
    logic beat_ok;     // beat consumed against the owed total
    logic fill_rej;    // fill dropped because the counter would overflow
    logic beat_stray;  // beat arrived with nothing owed
    logic burst_end;   // consumed beat closes a burst of earlier fills
  } trk_evt_t;

endpackage

// File: rtl/burst_trk_decode.sv
module burst_trk_decode
  import burst_trk_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int BEATS = 4
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic             fill_i,
  input  logic             beat_i,
  output trk_evt_t         evt_o,
  output logic [CNT_W-1:0] next_o
);

  localparam int MAX_CNT = (1 << CNT_W) - 1;
  localparam logic [CNT_W:0] BURST_W = (CNT_W+1)'(BEATS);

  // True when a fill of one burst still fits, given whether a beat leaves
  function automatic logic fill_fits(input logic [CNT_W-1:0] c, input logic early_beat);
    int room;
    int need;
    room = MAX_CNT - int'(c);
    need = BEATS - (early_beat ? 1 : 0);
    return need <= room;
  endfunction

  // True when consuming one beat at this count finishes a burst
  function automatic logic closes_burst(input logic [CNT_W-1:0] c);
    return (c != '0) && ((int'(c) % BEATS) == (1 % BEATS));
  endfunction

  // New total after the accepted events
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic add_burst,
                                                  input logic take_beat);
    logic [CNT_W:0] wide;
    wide = {1'b0, c};
    if (add_burst) wide = wide + BURST_W;
    if (take_beat) wide = wide - (CNT_W+1)'(1);
    return wide[CNT_W-1:0];
  endfunction

  logic early_beat;
  logic fill_ok;
  logic beat_ok;

  always_comb begin
    early_beat = beat_i && (count_i != '0);
    fill_ok    = fill_i && fill_fits(count_i, early_beat);
    beat_ok    = early_beat || (beat_i && fill_ok);

    evt_o.fill_ok    = fill_ok;
    evt_o.beat_ok    = beat_ok;
    evt_o.fill_rej   = fill_i && !fill_ok;
    evt_o.beat_stray = beat_i && !beat_ok;
    evt_o.burst_end  = early_beat && closes_burst(count_i);

    next_o = step_count(count_i, fill_ok, beat_ok);
  end

endmodule

// File: rtl/burst_trk_counter.sv
module burst_trk_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] next_i,
  output logic [CNT_W-1:0] count_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= next_i;
  end

endmodule

// File: rtl/burst_trk_flags.sv
module burst_trk_flags
  import burst_trk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  trk_evt_t evt_i,
  output logic     done_o,
  output logic     err_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= evt_i.burst_end;
      err_o  <= evt_i.fill_rej | evt_i.beat_stray;
    end
  end

endmodule

// File: rtl/burst_beat_tracker.sv
module burst_beat_tracker
  import burst_trk_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int BEATS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_req,
  input  logic             beat_vld,
  output logic [CNT_W-1:0] pend_beats,
  output logic             busy,
  output logic             burst_done,
  output logic             proto_err
);

  trk_evt_t         evt;
  logic [CNT_W-1:0] count_nxt;
  logic [CNT_W-1:0] count_q;

  burst_trk_decode #(.CNT_W(CNT_W), .BEATS(BEATS)) u_decode (
    .count_i (count_q),
    .fill_i  (fill_req),
    .beat_i  (beat_vld),
    .evt_o   (evt),
    .next_o  (count_nxt)
  );

  burst_trk_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .next_i  (count_nxt),
    .count_o (count_q)
  );

  burst_trk_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt),
    .done_o (burst_done),
    .err_o  (proto_err)
  );

  assign pend_beats = count_q;
  assign busy       = |count_q;

endmodule

// File: rtl/burst_trk_chk.sv
module burst_trk_chk
  import burst_trk_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int BEATS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fill_req,
  input logic             beat_vld,
  input logic [CNT_W-1:0] pend_beats,
  input logic             busy,
  input logic             burst_done,
  input logic             proto_err,
  input trk_evt_t         evt
);

  localparam int MAX_CNT = (1 << CNT_W) - 1;
  localparam int ROOM    = MAX_CNT - BEATS;

  AST_FILL_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !beat_vld && int'(pend_beats) <= ROOM) |=>
      int'(pend_beats) == int'($past(pend_beats)) + BEATS); // R1

  AST_BEAT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !fill_req && pend_beats != '0) |=>
      int'(pend_beats) == int'($past(pend_beats)) - 1); // R2

  AST_BOTH_NET: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && beat_vld && int'(pend_beats) <= ROOM) |=>
      int'(pend_beats) == int'($past(pend_beats)) + BEATS - 1); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_req && !beat_vld) |=> $stable(pend_beats)); // R4

  AST_PIPE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && pend_beats != '0 && int'(pend_beats) <= ROOM) |=> !proto_err); // R5

  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> $past(beat_vld) && $past(evt.beat_ok)); // R6

  AST_LAST_BEAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_beats == CNT_W'(1) && beat_vld && !fill_req) |=> (!busy && burst_done)); // R7

  AST_STRAY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !fill_req && pend_beats == '0) |=> (proto_err && pend_beats == '0)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !beat_vld && int'(pend_beats) > ROOM) |=>
      (proto_err && $stable(pend_beats))); // R9

  AST_REJECT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    evt.fill_rej |-> !evt.fill_ok); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (pend_beats == '0 && !burst_done && !proto_err)); // R10

  AST_STRAY_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    evt.beat_stray |-> (pend_beats == '0 && !fill_req)); // R8

endmodule

bind burst_beat_tracker burst_trk_chk #(.CNT_W(CNT_W), .BEATS(BEATS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fill_req   (fill_req),
  .beat_vld   (beat_vld),
  .pend_beats (pend_beats),
  .busy       (busy),
  .burst_done (burst_done),
  .proto_err  (proto_err),
  .evt        (evt)
);

// File: tb/burst_beat_tracker_test.sv
`timescale 1ns/1ps
module burst_beat_tracker_test;

  localparam int CNT_W   = 6;
  localparam int BEATS   = 4;
  localparam int MAX_CNT = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fill_req = 1'b0;
  logic             beat_vld = 1'b0;
  logic [CNT_W-1:0] pend_beats;
  logic             busy;
  logic             burst_done;
  logic             proto_err;

  int checks = 0;
  int failures = 0;
  int exp_count = 0;
  bit exp_done = 0;
  bit exp_err = 0;

  always #10 clk = ~clk;

  burst_beat_tracker #(.CNT_W(CNT_W), .BEATS(BEATS)) uut (
    .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .beat_vld(beat_vld),
    .pend_beats(pend_beats), .busy(busy), .burst_done(burst_done), .proto_err(proto_err)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // Reference owed total: a beat goes first to earlier bursts, then to a same-cycle fill
  function automatic int ref_next(input int c, input bit f, input bit b,
                                  output bit done, output bit err);
    bit old_beat = b && (c > 0);
    int after_beat = old_beat ? c - 1 : c;
    bit take_fill = f && (after_beat + BEATS <= MAX_CNT);
    bit new_beat = b && !old_beat && take_fill;
    done = old_beat && ((c - 1) % BEATS == 0);
    err  = (f && !take_fill) || (b && !old_beat && !new_beat);
    return after_beat + (take_fill ? BEATS : 0) - (new_beat ? 1 : 0);
  endfunction

  task automatic compare_all();
    check("R5 pend_beats", int'(pend_beats), exp_count);
    check("R7 busy", int'(busy), (exp_count != 0) ? 1 : 0);
    check("R6 burst_done", int'(burst_done), int'(exp_done));
    check("R8 R9 proto_err", int'(proto_err), int'(exp_err));
  endtask

  // Called at a falling edge: drive, advance model, compare at next falling edge
  task automatic step(input bit f, input bit b);
    bit d;
    bit e;
    fill_req = f;
    beat_vld = b;
    exp_count = ref_next(exp_count, f, b, d, e);
    exp_done = d;
    exp_err = e;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    int r;
    seed = 32'h5eed_1234;
    r = $urandom(seed);

    // R10: outputs held at zero during reset
    repeat (3) @(negedge clk);
    check("R10 pend_beats in reset", int'(pend_beats), 0);
    check("R10 burst_done in reset", int'(burst_done), 0);
    check("R10 proto_err in reset", int'(proto_err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 R2 R6: one fill, beats with idle gaps, done on the fourth
    step(1, 0);
    check("R1 single fill", int'(pend_beats), 4);
    step(0, 0);
    check("R4 idle holds", int'(pend_beats), 4);
    step(0, 1);
    check("R2 beat takes one", int'(pend_beats), 3);
    step(0, 0);
    step(0, 1);
    step(0, 1);
    step(0, 1);
    check("R6 done on fourth beat", int'(burst_done), 1);
    step(0, 0);
    check("R6 done lasts one cycle", int'(burst_done), 0);

    // R8: stray beat
    step(0, 1);
    check("R8 stray beat error", int'(proto_err), 1);
    check("R8 stray beat count", int'(pend_beats), 0);

    // R3 from zero, then R5 pipelined fill
    step(1, 1);
    check("R3 fill+beat from zero", int'(pend_beats), 3);
    check("R3 no error", int'(proto_err), 0);
    step(1, 0);
    check("R5 pipelined fill", int'(pend_beats), 7);
    step(1, 1);
    check("R3 fill+beat while owed", int'(pend_beats), 10);
    while (exp_count > 0) step(0, 1);
    check("R7 idle after drain", int'(busy), 0);

    // R9: fill the counter, then overflow
    for (int i = 0; i < 15; i++) step(1, 0);
    check("R9 near full", int'(pend_beats), 60);
    step(1, 0);
    check("R9 overflow error", int'(proto_err), 1);
    check("R9 overflow count held", int'(pend_beats), 60);
    step(1, 1);
    check("R9 fill with beat fits", int'(pend_beats), 63);
    step(1, 1);
    check("R9 rejected fill keeps beat", int'(pend_beats), 62);
    check("R9 rejected fill flagged", int'(proto_err), 1);
    while (exp_count > 0) step(0, 1);

    // Random traffic, biased per phase
    for (int i = 0; i < 4000; i++) begin
      int fw = (i % 1000 < 500) ? 20 : 35;
      bit f = ($urandom % 100) < fw;
      bit b = ($urandom % 100) < 60;
      step(f, b);
    end

    // R10: reset while busy
    while (exp_count < 8) step(1, 0);
    rst_n = 1'b0;
    exp_count = 0;
    exp_done = 0;
    exp_err = 0;
    #2;
    check("R10 reset clears count", int'(pend_beats), 0);
    @(negedge clk);
    compare_all();
    fill_req = 1'b0;
    beat_vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 1);
    check("R8 stray after reset", int'(proto_err), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule